// File: doc/BRIEF.md
# I2C Event Status Flag Controller

This block keeps the event flags of an I2C interface and decides when the clock line must be stretched. The serial bus engine reports what happened on the wire as single-cycle pulses: a start condition was sent, an acknowledge clock finished after a transmitted or a received byte, an address byte finished, the own address or a general call was recognised, a stop was seen, arbitration was lost. Software writes the START control and accesses the status and data registers. The block sees these accesses as strobes.

Four flags are kept: start-sent, master-mode, address-hit and transfer-done. Start-sent and transfer-done are acknowledged in two steps: a status read arms a pending latch, and a later data-register access consumes it. Address-hit is acknowledged by the status read alone. While address-hit or transfer-done is set, the block asks the bus engine to hold SCL low. An interrupt request is raised for start-sent, address-hit or transfer-done when interrupts are enabled. Every output is registered.

Top module: `i2c_stat_flags`

## Requirements
- R1: During synchronous reset (`rst` high) every flag, `irq` and `scl_hold` read 0 one cycle later.
- R2: `ev_start_done` sets `flag_start_sent`. It clears only when `sr_rd` arms the pending latch and the next data-register access is a `dr_wr`.
- R3: `start_wr` sets `flag_master`. Either `ev_stop` or `ev_arb_lost` clears it.
- R4: `ev_tx_ack` sets `flag_xfer_done` when `tx_addr_byte` is 0 (a data byte was sent).
- R5: `ev_rx_ack` sets `flag_xfer_done` only while `ack_en` is 1. With `ack_en` at 0 it has no effect.
- R6: `ev_tx_ack` with `tx_addr_byte` at 1 leaves `flag_xfer_done` unchanged. `ev_addr_done` then sets it.
- R7: `flag_xfer_done` clears when the data-register access that follows an `sr_rd` is either a `dr_rd` or a `dr_wr`.
- R8: `ev_addr_hit` or `ev_gen_call` sets `flag_addr_hit`. A single `sr_rd` clears it.
- R9: A data-register access consumes the pending latch. A data-register access with no pending status read has no effect on any flag. A `dr_rd` between `sr_rd` and `dr_wr` leaves `flag_start_sent` set.
- R10: When a set event and a clear condition for the same flag meet in one cycle, the flag ends up at 1.
- R11: While `pe` is 0, all flags and the pending latch are 0 one cycle later, and set events are ignored.
- R12: `irq` is 1 exactly when `irq_en` was 1 in the previous cycle and any of start-sent, address-hit or transfer-done is set. Master-mode never raises it.
- R13: `scl_hold` is 1 exactly when address-hit or transfer-done is set.
- R14: Every flag and output changes in the cycle after the clock edge that samples its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pe | input | 1 | Peripheral enable; 0 clears all state |
| irq_en | input | 1 | Interrupt enable |
| ack_en | input | 1 | Acknowledge enable for received bytes |
| start_wr | input | 1 | Software wrote the START control |
| tx_addr_byte | input | 1 | Level: the byte being sent is an address byte |
| ev_start_done | input | 1 | Pulse: start condition generated |
| ev_tx_ack | input | 1 | Pulse: acknowledge clock received after a sent byte |
| ev_rx_ack | input | 1 | Pulse: acknowledge clock sent after a received byte |
| ev_addr_done | input | 1 | Pulse: address phase completed |
| ev_addr_hit | input | 1 | Pulse: received address equals own address |
| ev_gen_call | input | 1 | Pulse: general call recognised |
| ev_stop | input | 1 | Pulse: stop condition detected |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| sr_rd | input | 1 | Strobe: status register read |
| dr_rd | input | 1 | Strobe: data register read |
| dr_wr | input | 1 | Strobe: data register write |
| flag_start_sent | output | 1 | Start-sent flag |
| flag_master | output | 1 | Master-mode flag |
| flag_addr_hit | output | 1 | Address-hit flag |
| flag_xfer_done | output | 1 | Transfer-done flag |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
Every flag, `irq` and `scl_hold` is due exactly one clock edge after the cycle in which its cause is presented, including the enables. The pending latch moves at the edge of the status read, so its effect shows one edge after the data-register access. The bench drives all strobes on the falling edge for one cycle. It clears them at the next falling edge and samples the outputs there, half a period after the edge that registered them. For two-step acknowledges it checks after each step that the flag is still set after the first and cleared after the second.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int NFLAG   = 4;
  localparam int FL_SB   = 0;
  localparam int FL_MSL  = 1;
  localparam int FL_ADDR = 2;
  localparam int FL_XFER = 3;

  typedef logic [NFLAG-1:0] flag_vec_t;

  localparam flag_vec_t IRQ_SRC_MASK  = flag_vec_t'((1 << FL_SB) | (1 << FL_ADDR) | (1 << FL_XFER));
  localparam flag_vec_t HOLD_SRC_MASK = flag_vec_t'((1 << FL_ADDR) | (1 << FL_XFER));
endpackage

// File: rtl/i2c_stat_seq.sv
module i2c_stat_seq
  import i2c_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pe,
  input  logic      sr_rd,
  input  logic      dr_rd,
  input  logic      dr_wr,
  output flag_vec_t acc_clr
);
  logic pend_q;
  logic pend_d;
  logic dr_any;

  assign dr_any = dr_rd | dr_wr;

  always_comb begin
    if (!pe)
      pend_d = 1'b0;
    else if (sr_rd)
      pend_d = 1'b1;
    else if (dr_any)
      pend_d = 1'b0;
    else
      pend_d = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      pend_q <= 1'b0;
    else
      pend_q <= pend_d;
  end

  always_comb begin
    acc_clr          = '0;
    acc_clr[FL_SB]   = pend_q & dr_wr;
    acc_clr[FL_XFER] = pend_q & dr_any;
    acc_clr[FL_ADDR] = sr_rd;
  end

  // R9
  pend_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (pe && sr_rd) |=> pend_q);

  // R9
  pend_consume_chk: assert property (@(posedge clk) disable iff (rst)
    (pe && !sr_rd && dr_any) |=> !pend_q);

  // R11
  pend_off_chk: assert property (@(posedge clk) disable iff (rst)
    !pe |=> !pend_q);
endmodule

// File: rtl/i2c_stat_decode.sv
module i2c_stat_decode
  import i2c_stat_pkg::*;
(
  input  logic      ack_en,
  input  logic      start_wr,
  input  logic      tx_addr_byte,
  input  logic      ev_start_done,
  input  logic      ev_tx_ack,
  input  logic      ev_rx_ack,
  input  logic      ev_addr_done,
  input  logic      ev_addr_hit,
  input  logic      ev_gen_call,
  input  logic      ev_stop,
  input  logic      ev_arb_lost,
  output flag_vec_t set_vec,
  output flag_vec_t bus_clr
);
  logic xfer_tx;
  logic xfer_rx;

  assign xfer_tx = ev_tx_ack & ~tx_addr_byte;
  assign xfer_rx = ev_rx_ack & ack_en;

  always_comb begin
    set_vec          = '0;
    set_vec[FL_SB]   = ev_start_done;
    set_vec[FL_MSL]  = start_wr;
    set_vec[FL_ADDR] = ev_addr_hit | ev_gen_call;
    set_vec[FL_XFER] = xfer_tx | xfer_rx | ev_addr_done;

    bus_clr          = '0;
    bus_clr[FL_MSL]  = ev_stop | ev_arb_lost;
  end
endmodule

// File: rtl/i2c_stat_cell.sv
module i2c_stat_cell (
  input  logic clk,
  input  logic rst,
  input  logic pe,
  input  logic set,
  input  logic clr,
  output logic q,
  output logic q_nxt
);
  always_comb begin
    if (!pe)
      q_nxt = 1'b0;
    else if (set)
      q_nxt = 1'b1;
    else if (clr)
      q_nxt = 1'b0;
    else
      q_nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      q <= 1'b0;
    else
      q <= q_nxt;
  end

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (pe && set) |=> q);

  // R11
  pe_off_chk: assert property (@(posedge clk) disable iff (rst)
    !pe |=> !q);

  // R14
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pe && !set && !clr) |=> $stable(q));
endmodule

// File: rtl/i2c_stat_out.sv
module i2c_stat_out
  import i2c_stat_pkg::*;
#(
  parameter flag_vec_t IRQ_MASK  = IRQ_SRC_MASK,
  parameter flag_vec_t HOLD_MASK = HOLD_SRC_MASK
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      irq_en,
  input  flag_vec_t flags_nxt,
  input  flag_vec_t flags_q,
  output logic      irq,
  output logic      scl_hold
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      scl_hold <= 1'b0;
    end else begin
      irq      <= irq_en & (|(flags_nxt & IRQ_MASK));
      scl_hold <= |(flags_nxt & HOLD_MASK);
    end
  end

  // R13
  scl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    scl_hold == (|(flags_q & HOLD_MASK)));

  // R12
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq == ($past(irq_en) && (|(flags_q & IRQ_MASK))));
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_stat_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pe,
  input  logic irq_en,
  input  logic ack_en,
  input  logic start_wr,
  input  logic tx_addr_byte,
  input  logic ev_start_done,
  input  logic ev_tx_ack,
  input  logic ev_rx_ack,
  input  logic ev_addr_done,
  input  logic ev_addr_hit,
  input  logic ev_gen_call,
  input  logic ev_stop,
  input  logic ev_arb_lost,
  input  logic sr_rd,
  input  logic dr_rd,
  input  logic dr_wr,
  output logic flag_start_sent,
  output logic flag_master,
  output logic flag_addr_hit,
  output logic flag_xfer_done,
  output logic irq,
  output logic scl_hold
);
  flag_vec_t set_vec;
  flag_vec_t bus_clr;
  flag_vec_t acc_clr;
  flag_vec_t clr_vec;
  flag_vec_t flags_q;
  flag_vec_t flags_nxt;

  i2c_stat_decode u_dec (
    .ack_en        (ack_en),
    .start_wr      (start_wr),
    .tx_addr_byte  (tx_addr_byte),
    .ev_start_done (ev_start_done),
    .ev_tx_ack     (ev_tx_ack),
    .ev_rx_ack     (ev_rx_ack),
    .ev_addr_done  (ev_addr_done),
    .ev_addr_hit   (ev_addr_hit),
    .ev_gen_call   (ev_gen_call),
    .ev_stop       (ev_stop),
    .ev_arb_lost   (ev_arb_lost),
    .set_vec       (set_vec),
    .bus_clr       (bus_clr)
  );

  i2c_stat_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .pe      (pe),
    .sr_rd   (sr_rd),
    .dr_rd   (dr_rd),
    .dr_wr   (dr_wr),
    .acc_clr (acc_clr)
  );

  assign clr_vec = bus_clr | acc_clr;

  for (genvar g = 0; g < NFLAG; g++) begin : g_cell
    i2c_stat_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .pe    (pe),
      .set   (set_vec[g]),
      .clr   (clr_vec[g]),
      .q     (flags_q[g]),
      .q_nxt (flags_nxt[g])
    );
  end

  i2c_stat_out u_out (
    .clk       (clk),
    .rst       (rst),
    .irq_en    (irq_en),
    .flags_nxt (flags_nxt),
    .flags_q   (flags_q),
    .irq       (irq),
    .scl_hold  (scl_hold)
  );

  assign flag_start_sent = flags_q[FL_SB];
  assign flag_master     = flags_q[FL_MSL];
  assign flag_addr_hit   = flags_q[FL_ADDR];
  assign flag_xfer_done  = flags_q[FL_XFER];

  // R6
  addr_byte_no_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    (pe && !flag_xfer_done && ev_tx_ack && tx_addr_byte && !ev_addr_done && !ev_rx_ack)
      |=> !flag_xfer_done);

  // R8
  addr_hit_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (pe && sr_rd && !ev_addr_hit && !ev_gen_call) |=> !flag_addr_hit);

  // R11
  pe_off_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !pe |=> (!flag_start_sent && !flag_master && !flag_addr_hit && !flag_xfer_done
             && !irq && !scl_hold));

  // R3
  master_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (pe && (ev_stop || ev_arb_lost) && !start_wr) |=> !flag_master);
endmodule

// File: tb/i2c_stat_flags_tb_top.sv
`timescale 1ns/1ps
module i2c_stat_flags_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pe = 1'b0, irq_en = 1'b0, ack_en = 1'b0;
  logic start_wr = 1'b0, tx_addr_byte = 1'b0;
  logic ev_start_done = 1'b0, ev_tx_ack = 1'b0, ev_rx_ack = 1'b0, ev_addr_done = 1'b0;
  logic ev_addr_hit = 1'b0, ev_gen_call = 1'b0, ev_stop = 1'b0, ev_arb_lost = 1'b0;
  logic sr_rd = 1'b0, dr_rd = 1'b0, dr_wr = 1'b0;
  logic flag_start_sent, flag_master, flag_addr_hit, flag_xfer_done, irq, scl_hold;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_stat_flags dut_i (
    .clk(clk), .rst(rst), .pe(pe), .irq_en(irq_en), .ack_en(ack_en),
    .start_wr(start_wr), .tx_addr_byte(tx_addr_byte),
    .ev_start_done(ev_start_done), .ev_tx_ack(ev_tx_ack), .ev_rx_ack(ev_rx_ack),
    .ev_addr_done(ev_addr_done), .ev_addr_hit(ev_addr_hit), .ev_gen_call(ev_gen_call),
    .ev_stop(ev_stop), .ev_arb_lost(ev_arb_lost),
    .sr_rd(sr_rd), .dr_rd(dr_rd), .dr_wr(dr_wr),
    .flag_start_sent(flag_start_sent), .flag_master(flag_master),
    .flag_addr_hit(flag_addr_hit), .flag_xfer_done(flag_xfer_done),
    .irq(irq), .scl_hold(scl_hold)
  );

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: pulses set before the call are seen at the next rising edge
  task automatic step();
    @(negedge clk);
    start_wr = 0; ev_start_done = 0; ev_tx_ack = 0; ev_rx_ack = 0; ev_addr_done = 0;
    ev_addr_hit = 0; ev_gen_call = 0; ev_stop = 0; ev_arb_lost = 0;
    sr_rd = 0; dr_rd = 0; dr_wr = 0;
  endtask

  task automatic t_reset();
    rst = 1; pe = 1; ev_start_done = 1; start_wr = 1; step();
    chk("R1 start", flag_start_sent, 0);
    chk("R1 master", flag_master, 0);
    chk("R1 xfer", flag_xfer_done, 0);
    chk("R1 hold", scl_hold, 0);
    rst = 0; step();
  endtask

  task automatic t_start();
    irq_en = 1;
    start_wr = 1; step();
    chk("R3 master set", flag_master, 1);
    chk("R12 master no irq", irq, 0);
    ev_start_done = 1; step();
    chk("R2 start set", flag_start_sent, 1);
    chk("R12 irq on start", irq, 1);
    chk("R13 no hold on start", scl_hold, 0);
    sr_rd = 1; step();
    chk("R2 after status read", flag_start_sent, 1);
    dr_wr = 1; step();
    chk("R2 cleared", flag_start_sent, 0);
    chk("R12 irq drop", irq, 0);
    ev_stop = 1; step();
    chk("R3 stop clears", flag_master, 0);
    start_wr = 1; step();
    ev_arb_lost = 1; step();
    chk("R3 arb clears", flag_master, 0);
  endtask

  task automatic t_tx();
    tx_addr_byte = 0; ev_tx_ack = 1; step();
    chk("R4 tx set", flag_xfer_done, 1);
    chk("R13 hold", scl_hold, 1);
    dr_wr = 1; step();
    chk("R9 no pending", flag_xfer_done, 1);
    sr_rd = 1; step();
    dr_rd = 1; step();
    chk("R7 cleared by read", flag_xfer_done, 0);
    chk("R13 release", scl_hold, 0);
  endtask

  task automatic t_rx();
    ack_en = 0; ev_rx_ack = 1; step();
    chk("R5 nack ignored", flag_xfer_done, 0);
    ack_en = 1; ev_rx_ack = 1; step();
    chk("R5 rx set", flag_xfer_done, 1);
    sr_rd = 1; step();
    dr_wr = 1; step();
    chk("R7 cleared by write", flag_xfer_done, 0);
  endtask

  task automatic t_addr_byte();
    tx_addr_byte = 1; ev_tx_ack = 1; step();
    chk("R6 no set on addr ack", flag_xfer_done, 0);
    ev_addr_done = 1; step();
    chk("R6 set on addr done", flag_xfer_done, 1);
    tx_addr_byte = 0;
    sr_rd = 1; step();
    dr_wr = 1; step();
    chk("R7 clear after addr", flag_xfer_done, 0);
  endtask

  task automatic t_addr_hit();
    ev_addr_hit = 1; step();
    chk("R8 hit set", flag_addr_hit, 1);
    chk("R13 hold on hit", scl_hold, 1);
    chk("R12 irq on hit", irq, 1);
    sr_rd = 1; step();
    chk("R8 cleared by status", flag_addr_hit, 0);
    dr_rd = 1; step();
    ev_gen_call = 1; step();
    chk("R8 gen call set", flag_addr_hit, 1);
    sr_rd = 1; step();
    chk("R8 gen call cleared", flag_addr_hit, 0);
    dr_rd = 1; step();
  endtask

  task automatic t_cancel();
    ev_start_done = 1; step();
    sr_rd = 1; step();
    dr_rd = 1; step();
    chk("R9 read keeps start", flag_start_sent, 1);
    dr_wr = 1; step();
    chk("R9 cancelled", flag_start_sent, 1);
    sr_rd = 1; step();
    dr_wr = 1; step();
    chk("R2 cleared after rearm", flag_start_sent, 0);
  endtask

  task automatic t_set_wins();
    ev_tx_ack = 1; step();
    sr_rd = 1; step();
    dr_rd = 1; ev_tx_ack = 1; step();
    chk("R10 xfer set wins", flag_xfer_done, 1);
    sr_rd = 1; step();
    dr_rd = 1; step();
    chk("R7 clear", flag_xfer_done, 0);
    start_wr = 1; ev_stop = 1; step();
    chk("R10 master set wins", flag_master, 1);
    ev_stop = 1; step();
    sr_rd = 1; ev_addr_hit = 1; step();
    chk("R10 hit set wins", flag_addr_hit, 1);
    sr_rd = 1; step();
    dr_rd = 1; step();
  endtask

  task automatic t_pe();
    start_wr = 1; ev_start_done = 1; ev_addr_hit = 1; ev_tx_ack = 1; step();
    chk("R11 pre", scl_hold, 1);
    pe = 0; step();
    chk("R11 start", flag_start_sent, 0);
    chk("R11 master", flag_master, 0);
    chk("R11 hit", flag_addr_hit, 0);
    chk("R11 xfer", flag_xfer_done, 0);
    chk("R11 irq", irq, 0);
    ev_addr_hit = 1; step();
    chk("R11 event ignored", flag_addr_hit, 0);
    pe = 1; sr_rd = 1; step();
    pe = 0; step();
    pe = 1; ev_tx_ack = 1; step();
    dr_rd = 1; step();
    chk("R11 pending dropped", flag_xfer_done, 1);
    sr_rd = 1; step();
    dr_rd = 1; step();
  endtask

  task automatic t_irq();
    irq_en = 0; ev_tx_ack = 1; step();
    chk("R12 masked", irq, 0);
    irq_en = 1; step();
    chk("R12 unmasked", irq, 1);
    sr_rd = 1; step();
    dr_wr = 1; step();
    start_wr = 1; step();
    chk("R12 master only", irq, 0);
    ev_stop = 1; step();
  endtask

  initial begin
    step();
    t_reset();
    t_start();
    t_tx();
    t_rx();
    t_addr_byte();
    t_addr_hit();
    t_cancel();
    t_set_wins();
    t_pe();
    t_irq();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule